// File: doc/BRIEF.md
# Event-Timer Register Front End

This block is the memory-mapped register file in front of a multi-timer event-timer peripheral. It holds a read-only capability word, a two-bit general configuration, a free-running 64-bit main counter, and one group of three 64-bit words for each timer: configuration, comparator and route. A bus master issues one request per cycle. The request carries a byte address, a length of 1, 2, 4 or 8 bytes and, for a write, data. The block answers on the next clock edge with read data and an error flag.

Each access is mapped onto the 64-bit register that holds it. A read takes the addressed bytes out of that register. A write merges the new bytes into the current value lane by lane. A per-register writable mask then makes sure that read-only and reserved bits keep their values. Changes of the global enable and of each timer's enable bit are reported to the timer channels as one-cycle arm and stop pulses. Comparator sequencing and interrupt delivery belong to the channels, not to this block.

Top module: `evtmr_regs`

## Requirements
- R1: A request whose length is not 1, 2, 4 or 8, or whose address is not a multiple of its length, completes with `rsp_err`=1 and changes no state. A rejected read returns all ones.
- R2: A read selects the register at the address with its low three bits cleared. It shifts that register right by 8 × (address bits 2:0) and keeps only the requested number of low bytes. The response appears on the clock edge that samples the request.
- R3: A write shorter than 8 bytes replaces only the addressed byte lanes of the register. All other lanes keep their old values.
- R4: The general configuration word (offset 0x010) has two writable bits: bit 0 is the global enable (`gen_enable`) and bit 1 is the legacy routing select (`legacy_route`). Its other bits read as zero. It resets to zero.
- R5: A timer configuration word resets to {ROUTE_CAP, 32'h0000_0030}, where bit 5 means 64-bit capable and bit 4 means periodic capable. Only the bits in 0x3F4E are writable, and every other bit keeps its value. Bit 2 is the timer enable and bit 8 selects 32-bit mode.
- R6: The capability word (offset 0x000) reads {TICK_FS, 32'h8086_A201} with the default parameters. Writes to it are accepted without error and have no effect.
- R7: The fixed registers sit at these offsets: 0x000 capability, 0x010 configuration, 0x020 status (reads zero, ignores writes) and 0x0F0 main counter. Timer n's group starts at 0x100 + 0x20·n: configuration at +0x00, comparator at +0x08 and route at +0x10. Offsets that are not mapped, including +0x18 of a group and everything at or above 0x160, read zero and ignore writes without error.
- R8: The main counter increases by one per clock while the global enable is set and holds its value while it is clear. A write to the counter loads the merged value, and the counter's live count is the old value used for the merge.
- R9: A 0→1 change of the global enable pulses `arm_evt[n]` for every timer whose enable bit is set. A 1→0 change pulses `stop_evt` for all timers. A timer enable bit rising while the global enable is set pulses that timer's `arm_evt`. A timer enable bit falling pulses its `stop_evt`. All of these pulses appear together with the response.
- R10: A write to the main counter while the global enable is set pulses `cnt_wr_live` for one cycle. With the global enable clear, the pulse stays low.
- R11: Every comparator resets to all ones. While a timer's 32-bit mode bit is set, the upper half of its comparator reads zero: setting the bit clears that half, and comparator writes drop their upper 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the register window |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_err | output | 1 | Request rejected for length or alignment |
| rsp_rdata | output | 64 | Read data, right-aligned |
| gen_enable | output | 1 | Global enable bit |
| legacy_route | output | 1 | Legacy routing select bit |
| main_count | output | 64 | Live main counter value |
| arm_evt | output | NTMR | One-cycle arm pulse per timer |
| stop_evt | output | NTMR | One-cycle stop pulse per timer |
| cnt_wr_live | output | 1 | Counter written while running |

## Verification
A wrong lane mask or shift shows up at once: it either corrupts the neighbouring bytes that a later full-width read of the same register returns, or it puts the wrong bytes in the response one cycle after a narrow read. A read-only bit that has leaked shows up as a changed reset pattern when the configuration word is read back after an all-ones write. An enable state that is out of step shows up in the same response cycle as a missing or unexpected arm or stop pulse. Within one or two requests it also shows up as a counter that advances or holds when it should not.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_GCFG,
        SEL_STAT,
        SEL_CNT,
        SEL_TCFG,
        SEL_TCMP,
        SEL_TRTE
    } sel_e;

    localparam logic [63:0] GCFG_WMASK   = 64'h0000_0000_0000_0003;
    localparam logic [63:0] TCFG_WMASK   = 64'h0000_0000_0000_3F4E;
    localparam int          GCFG_EN_BIT  = 0;
    localparam int          GCFG_LEG_BIT = 1;
    localparam int          TCFG_EN_BIT  = 2;
    localparam int          TCFG_W32_BIT = 8;

    // byte-count to a right-aligned bit mask; illegal lengths give zero
    function automatic logic [63:0] width_mask(input logic [3:0] len);
        case (len)
            4'd1:    return 64'h0000_0000_0000_00FF;
            4'd2:    return 64'h0000_0000_0000_FFFF;
            4'd4:    return 64'h0000_0000_FFFF_FFFF;
            4'd8:    return '1;
            default: return '0;
        endcase
    endfunction

    function automatic logic [63:0] bit_merge(input logic [63:0] nv,
                                              input logic [63:0] ov,
                                              input logic [63:0] keep_new);
        return (nv & keep_new) | (ov & ~keep_new);
    endfunction

endpackage

// File: rtl/evtmr_decode.sv
module evtmr_decode
    import evtmr_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int NTMR    = 3,
    parameter int TBASE   = 'h100,
    parameter int TSTRIDE = 'h20,
    parameter int TIDX_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        len,
    output logic              err,
    output sel_e              sel,
    output logic [TIDX_W-1:0] tidx,
    output logic [2:0]        off
);
    localparam int SUB_W = $clog2(TSTRIDE);
    localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'('h000);
    localparam logic [ADDR_W-1:0] A_GCFG = ADDR_W'('h010);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h020);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'('h0F0);
    localparam logic [ADDR_W-1:0] T_LO   = ADDR_W'(TBASE);
    localparam logic [ADDR_W-1:0] T_HI   = ADDR_W'(TBASE + NTMR * TSTRIDE);

    logic [ADDR_W-1:0] word;
    logic [ADDR_W-1:0] rel;
    logic [SUB_W-1:0]  sub;
    logic              len_ok;
    logic [3:0]        lm1;

    always_comb begin
        len_ok = (len == 4'd1) || (len == 4'd2) || (len == 4'd4) || (len == 4'd8);
        lm1    = len - 4'd1;
        err    = !len_ok || ((addr[2:0] & lm1[2:0]) != 3'd0);
        off    = addr[2:0];
        word   = {addr[ADDR_W-1:3], 3'b000};
        rel    = word - T_LO;
        sub    = rel[SUB_W-1:0];
        tidx   = TIDX_W'(rel >> SUB_W);
        sel    = SEL_NONE;
        if (word == A_CAP)       sel = SEL_CAP;
        else if (word == A_GCFG) sel = SEL_GCFG;
        else if (word == A_STAT) sel = SEL_STAT;
        else if (word == A_CNT)  sel = SEL_CNT;
        else if (word >= T_LO && word < T_HI) begin
            if (sub == SUB_W'(0))       sel = SEL_TCFG;
            else if (sub == SUB_W'(8))  sel = SEL_TCMP;
            else if (sub == SUB_W'(16)) sel = SEL_TRTE;
        end
    end

    // R1: an illegal length is never accepted
    always_comb begin
        if (!len_ok) p_badlen_err_r1: assert (err);
    end

endmodule

// File: rtl/evtmr_lane.sv
module evtmr_lane
    import evtmr_pkg::*;
(
    input  logic [63:0] old_val,
    input  logic [63:0] wdata,
    input  logic [2:0]  off,
    input  logic [3:0]  len,
    output logic [63:0] rd_val,
    output logic [63:0] wr_val
);
    logic [5:0]  sh;
    logic [63:0] wm;
    logic [63:0] lanes;

    always_comb begin
        sh     = {off, 3'b000};
        wm     = width_mask(len);
        lanes  = wm << sh;
        rd_val = (old_val >> sh) & wm;
        wr_val = bit_merge(wdata << sh, old_val, lanes);
    end

endmodule

// File: rtl/evtmr_regs.sv
module evtmr_regs
    import evtmr_pkg::*;
#(
    parameter int          NTMR      = 3,
    parameter int          ADDR_W    = 10,
    parameter logic [31:0] TICK_FS   = 32'd10_000_000,
    parameter logic [31:0] ROUTE_CAP = 32'h00FF_0000,
    parameter logic [15:0] VENDOR    = 16'h8086,
    parameter logic [7:0]  REV       = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_len,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic              gen_enable,
    output logic              legacy_route,
    output logic [63:0]       main_count,
    output logic [NTMR-1:0]   arm_evt,
    output logic [NTMR-1:0]   stop_evt,
    output logic              cnt_wr_live
);
    localparam int          TIDX_W   = (NTMR > 1) ? $clog2(NTMR) : 1;
    localparam logic [63:0] CAP_WORD = {TICK_FS, VENDOR, 1'b1, 1'b0, 1'b1,
                                        5'(NTMR - 1), REV};
    localparam logic [63:0] TCFG_RST = {ROUTE_CAP, 32'h0000_0030};

    typedef struct packed {
        logic [1:0]             gcfg;
        logic [63:0]            cnt;
        logic [NTMR-1:0][63:0]  tcfg;
        logic [NTMR-1:0][63:0]  tcmp;
        logic [NTMR-1:0][63:0]  trte;
        logic                   rsp_valid;
        logic                   rsp_err;
        logic                   rsp_wr;
        logic [63:0]            rsp_data;
        logic [NTMR-1:0]        arm;
        logic [NTMR-1:0]        stop;
        logic                   cnt_live;
    } st_t;

    st_t st_q, st_d;

    logic              dec_err;
    sel_e              dec_sel;
    logic [TIDX_W-1:0] dec_tidx;
    logic [2:0]        dec_off;
    logic [63:0]       old_val;
    logic [63:0]       rd_val;
    logic [63:0]       wr_val;
    logic [63:0]       tcfg_new;
    logic [63:0]       tcmp_new;
    logic              g_rise;
    logic              g_fall;

    evtmr_decode #(
        .ADDR_W (ADDR_W),
        .NTMR   (NTMR),
        .TBASE  ('h100),
        .TSTRIDE('h20),
        .TIDX_W (TIDX_W)
    ) u_dec (
        .addr(req_addr),
        .len (req_len),
        .err (dec_err),
        .sel (dec_sel),
        .tidx(dec_tidx),
        .off (dec_off)
    );

    always_comb begin
        case (dec_sel)
            SEL_CAP:  old_val = CAP_WORD;
            SEL_GCFG: old_val = {62'd0, st_q.gcfg};
            SEL_CNT:  old_val = st_q.cnt;
            SEL_TCFG: old_val = st_q.tcfg[dec_tidx];
            SEL_TCMP: old_val = st_q.tcmp[dec_tidx];
            SEL_TRTE: old_val = st_q.trte[dec_tidx];
            default:  old_val = '0;
        endcase
    end

    evtmr_lane u_lane (
        .old_val(old_val),
        .wdata  (req_wdata),
        .off    (dec_off),
        .len    (req_len),
        .rd_val (rd_val),
        .wr_val (wr_val)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_wr    = req_write;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_data  = '0;
        st_d.arm       = '0;
        st_d.stop      = '0;
        st_d.cnt_live  = 1'b0;
        tcfg_new       = '0;
        tcmp_new       = '0;
        g_rise         = 1'b0;
        g_fall         = 1'b0;

        if (st_q.gcfg[GCFG_EN_BIT]) st_d.cnt = st_q.cnt + 64'd1;

        if (req_valid) begin
            if (dec_err) begin
                st_d.rsp_err  = 1'b1;
                st_d.rsp_data = req_write ? '0 : '1;
            end else if (!req_write) begin
                st_d.rsp_data = rd_val;
            end else begin
                case (dec_sel)
                    SEL_GCFG: begin
                        st_d.gcfg = 2'(bit_merge(wr_val, old_val, GCFG_WMASK));
                        g_rise = !st_q.gcfg[GCFG_EN_BIT] && st_d.gcfg[GCFG_EN_BIT];
                        g_fall = st_q.gcfg[GCFG_EN_BIT] && !st_d.gcfg[GCFG_EN_BIT];
                        for (int i = 0; i < NTMR; i++) begin
                            st_d.arm[i]  = g_rise && st_q.tcfg[i][TCFG_EN_BIT];
                            st_d.stop[i] = g_fall;
                        end
                    end
                    SEL_CNT: begin
                        st_d.cnt      = wr_val;
                        st_d.cnt_live = st_q.gcfg[GCFG_EN_BIT];
                    end
                    SEL_TCFG: begin
                        tcfg_new = bit_merge(wr_val, old_val, TCFG_WMASK);
                        st_d.tcfg[dec_tidx] = tcfg_new;
                        if (tcfg_new[TCFG_W32_BIT])
                            st_d.tcmp[dec_tidx][63:32] = '0;
                        if (!old_val[TCFG_EN_BIT] && tcfg_new[TCFG_EN_BIT])
                            st_d.arm[dec_tidx] = st_q.gcfg[GCFG_EN_BIT];
                        if (old_val[TCFG_EN_BIT] && !tcfg_new[TCFG_EN_BIT])
                            st_d.stop[dec_tidx] = 1'b1;
                    end
                    SEL_TCMP: begin
                        tcmp_new = wr_val;
                        if (st_q.tcfg[dec_tidx][TCFG_W32_BIT])
                            tcmp_new[63:32] = '0;
                        st_d.tcmp[dec_tidx] = tcmp_new;
                    end
                    SEL_TRTE: st_d.trte[dec_tidx] = wr_val;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.tcfg <= {NTMR{TCFG_RST}};
            st_q.tcmp <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid    = st_q.rsp_valid;
    assign rsp_err      = st_q.rsp_err;
    assign rsp_rdata    = st_q.rsp_data;
    assign gen_enable   = st_q.gcfg[GCFG_EN_BIT];
    assign legacy_route = st_q.gcfg[GCFG_LEG_BIT];
    assign main_count   = st_q.cnt;
    assign arm_evt      = st_q.arm;
    assign stop_evt     = st_q.stop;
    assign cnt_wr_live  = st_q.cnt_live;

    // R2: every request is answered on the next edge
    p_resp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1: a rejected read returns all ones
    p_err_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err && !st_q.rsp_wr) |-> (rsp_rdata == '1));

    // R8: halted counter holds unless written
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_enable && !(req_valid && req_write)) |=> $stable(main_count));

    // R8: running counter steps by one unless written
    p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_enable && !(req_valid && req_write)) |=> (main_count == $past(main_count) + 64'd1));

    // R9: global disable stops every timer in the same cycle
    p_fall_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gen_enable) |-> (stop_evt == '1));

    // R9: a timer is never armed and stopped at once
    p_arm_stop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_evt & stop_evt) == '0);

    // R10: live-write flag only while running before the write
    p_live_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_live |-> $past(gen_enable));

    for (genvar g = 0; g < NTMR; g++) begin : g_tchk
        // R5: non-writable configuration bits keep their reset pattern
        p_tcfg_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.tcfg[g] & ~TCFG_WMASK) == (TCFG_RST & ~TCFG_WMASK));
        // R11: 32-bit mode keeps the comparator's upper half clear
        p_cmp32_r11: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.tcfg[g][TCFG_W32_BIT] |-> (st_q.tcmp[g][63:32] == 32'd0));
    end

endmodule

// File: tb/sim_evtmr_regs.sv
`timescale 1ns/1ps
module sim_evtmr_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [3:0]  req_len = 4'd8;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, gen_enable, legacy_route, cnt_wr_live;
    logic [63:0] rsp_rdata, main_count;
    logic [2:0]  arm_evt, stop_evt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    evtmr_regs u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .gen_enable(gen_enable), .legacy_route(legacy_route),
        .main_count(main_count), .arm_evt(arm_evt), .stop_evt(stop_evt),
        .cnt_wr_live(cnt_wr_live)
    );

    typedef struct packed {
        logic        wr;
        logic [9:0]  addr;
        logic [3:0]  len;
        logic [63:0] wdata;
        logic [63:0] exp;
        logic        chk;
        logic        err;
        logic [7:0]  req;
    } vec_t;

    localparam logic [63:0] CAP = 64'h0098_9680_8086_A201;
    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'h000, 4'd8, 64'h0, CAP,                    1'b1, 1'b0, 8'd6},  // R6
        '{1'b0, 10'h004, 4'd4, 64'h0, 64'h0000_0000_0098_9680, 1'b1, 1'b0, 8'd2},  // R2
        '{1'b0, 10'h002, 4'd2, 64'h0, 64'h8086,               1'b1, 1'b0, 8'd2},  // R2
        '{1'b0, 10'h001, 4'd1, 64'h0, 64'hA2,                 1'b1, 1'b0, 8'd2},  // R2
        '{1'b0, 10'h003, 4'd2, 64'h0, '1,                     1'b1, 1'b1, 8'd1},  // R1
        '{1'b0, 10'h000, 4'd3, 64'h0, '1,                     1'b1, 1'b1, 8'd1},  // R1
        '{1'b1, 10'h000, 4'd8, 64'h0, 64'h0,                  1'b0, 1'b0, 8'd6},  // R6
        '{1'b0, 10'h000, 4'd8, 64'h0, CAP,                    1'b1, 1'b0, 8'd6},  // R6
        '{1'b0, 10'h100, 4'd8, 64'h0, 64'h00FF_0000_0000_0030, 1'b1, 1'b0, 8'd5},  // R5
        '{1'b1, 10'h100, 4'd8, '1,    64'h0,                  1'b0, 1'b0, 8'd5},  // R5
        '{1'b0, 10'h100, 4'd8, 64'h0, 64'h00FF_0000_0000_3F7E, 1'b1, 1'b0, 8'd5},  // R5
        '{1'b0, 10'h108, 4'd8, 64'h0, 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0, 8'd11}, // R11
        '{1'b0, 10'h128, 4'd8, 64'h0, '1,                     1'b1, 1'b0, 8'd11}, // R11
        '{1'b1, 10'h12C, 4'd4, 64'h1234_5678, 64'h0,          1'b0, 1'b0, 8'd3},  // R3
        '{1'b0, 10'h128, 4'd8, 64'h0, 64'h1234_5678_FFFF_FFFF, 1'b1, 1'b0, 8'd3},  // R3
        '{1'b1, 10'h129, 4'd1, 64'hAB, 64'h0,                 1'b0, 1'b0, 8'd3},  // R3
        '{1'b0, 10'h128, 4'd8, 64'h0, 64'h1234_5678_FFFF_ABFF, 1'b1, 1'b0, 8'd3},  // R3
        '{1'b0, 10'h12C, 4'd2, 64'h0, 64'h5678,               1'b1, 1'b0, 8'd2},  // R2
        '{1'b1, 10'h130, 4'd8, 64'hDEAD_BEEF_0123_4567, 64'h0, 1'b0, 1'b0, 8'd7}, // R7
        '{1'b0, 10'h130, 4'd8, 64'h0, 64'hDEAD_BEEF_0123_4567, 1'b1, 1'b0, 8'd7}, // R7
        '{1'b1, 10'h160, 4'd8, 64'h5555_5555_5555_5555, 64'h0, 1'b0, 1'b0, 8'd7}, // R7
        '{1'b0, 10'h160, 4'd8, 64'h0, 64'h0,                  1'b1, 1'b0, 8'd7},  // R7
        '{1'b0, 10'h118, 4'd8, 64'h0, 64'h0,                  1'b1, 1'b0, 8'd7},  // R7
        '{1'b1, 10'h020, 4'd8, '1,    64'h0,                  1'b0, 1'b0, 8'd7},  // R7
        '{1'b0, 10'h020, 4'd8, 64'h0, 64'h0,                  1'b1, 1'b0, 8'd7},  // R7
        '{1'b1, 10'h104, 4'd8, 64'h0, 64'h0,                  1'b0, 1'b1, 8'd1},  // R1
        '{1'b0, 10'h100, 4'd8, 64'h0, 64'h00FF_0000_0000_3F7E, 1'b1, 1'b0, 8'd1},  // R1
        '{1'b0, 10'h0F0, 4'd8, 64'h0, 64'h0,                  1'b1, 1'b0, 8'd8},  // R8
        '{1'b1, 10'h0F0, 4'd8, 64'h100, 64'h0,                1'b0, 1'b0, 8'd8},  // R8
        '{1'b0, 10'h0F0, 4'd8, 64'h0, 64'h100,                1'b1, 1'b0, 8'd8},  // R8
        '{1'b1, 10'h108, 4'd8, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0, 1'b0, 1'b0, 8'd11}, // R11
        '{1'b0, 10'h108, 4'd8, 64'h0, 64'h0000_0000_CCCC_DDDD, 1'b1, 1'b0, 8'd11}, // R11
        '{1'b0, 10'h010, 4'd8, 64'h0, 64'h0,                  1'b1, 1'b0, 8'd4}   // R4
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one request starting at a negedge; returns at the next negedge
    task automatic do_req(input logic wr, input logic [9:0] a, input logic [3:0] l,
                          input logic [63:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_len   = l;
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    logic [63:0] a_val, b_val;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state of the outputs (R4, R8, R9)
        check(!rsp_valid, "R2 reset rsp_valid", 64'(rsp_valid), 64'h0);
        check(!gen_enable && !legacy_route, "R4 reset config", {62'd0, legacy_route, gen_enable}, 64'h0);
        check(main_count == 64'h0, "R8 reset counter", main_count, 64'h0);
        check(arm_evt == 3'b0 && stop_evt == 3'b0, "R9 reset events", {58'd0, arm_evt, stop_evt}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].wr, VECS[i].addr, VECS[i].len, VECS[i].wdata);
            check(rsp_valid && rsp_err == VECS[i].err,
                  $sformatf("R%0d vec%0d err", VECS[i].req, i), 64'(rsp_err), 64'(VECS[i].err));
            if (VECS[i].chk)
                check(rsp_rdata == VECS[i].exp,
                      $sformatf("R%0d vec%0d data", VECS[i].req, i), rsp_rdata, VECS[i].exp);
        end

        // R9: timer enable rising while global is off gives no arm
        do_req(1'b1, 10'h140, 4'd1, 64'h04);
        check(arm_evt == 3'b000, "R9 arm while global off", 64'(arm_evt), 64'h0);
        // R5: byte write merged through the writable mask
        do_req(1'b0, 10'h140, 4'd1, 64'h0);
        check(rsp_rdata == 64'h34, "R5 masked byte merge", rsp_rdata, 64'h34);

        // R9, R4: global enable rise arms enabled timers 0 and 2
        do_req(1'b1, 10'h010, 4'd8, '1);
        check(arm_evt == 3'b101, "R9 arm on global rise", 64'(arm_evt), 64'h5);
        check(stop_evt == 3'b000, "R9 no stop on rise", 64'(stop_evt), 64'h0);
        check(gen_enable && legacy_route, "R4 enable and legacy bits", {62'd0, legacy_route, gen_enable}, 64'h3);
        do_req(1'b0, 10'h010, 4'd8, 64'h0);
        check(rsp_rdata == 64'h3, "R4 config readback", rsp_rdata, 64'h3);

        // R8: running counter advances one per clock
        do_req(1'b0, 10'h0F0, 4'd8, 64'h0);
        a_val = rsp_rdata;
        do_req(1'b0, 10'h0F0, 4'd8, 64'h0);
        b_val = rsp_rdata;
        check(b_val == a_val + 64'd1, "R8 counter runs", b_val, a_val + 64'd1);

        // R10: counter write while running is flagged; R3 upper-half merge
        do_req(1'b1, 10'h0F4, 4'd4, 64'h1);
        check(cnt_wr_live, "R10 live write flagged", 64'(cnt_wr_live), 64'h1);
        do_req(1'b0, 10'h0F4, 4'd4, 64'h0);
        check(rsp_rdata == 64'h1, "R3 counter upper word", rsp_rdata, 64'h1);

        // R9: global disable stops all timers
        do_req(1'b1, 10'h010, 4'd1, 64'h00);
        check(stop_evt == 3'b111, "R9 stop on global fall", 64'(stop_evt), 64'h7);
        check(!gen_enable, "R4 enable cleared", 64'(gen_enable), 64'h0);

        // R8: halted counter holds
        do_req(1'b0, 10'h0F0, 4'd8, 64'h0);
        a_val = rsp_rdata;
        repeat (3) @(negedge clk);
        do_req(1'b0, 10'h0F0, 4'd8, 64'h0);
        b_val = rsp_rdata;
        check(b_val == a_val, "R8 counter frozen", b_val, a_val);
        check(a_val[63:32] == 32'h1, "R8 merged load kept", {32'd0, a_val[63:32]}, 64'h1);

        // R10: counter write while halted is not flagged
        do_req(1'b1, 10'h0F0, 4'd8, 64'h0);
        check(!cnt_wr_live, "R10 halted write not flagged", 64'(cnt_wr_live), 64'h0);

        // R9: per-timer enable edges
        do_req(1'b1, 10'h010, 4'd1, 64'h01);
        check(arm_evt == 3'b101, "R9 re-arm on rise", 64'(arm_evt), 64'h5);
        do_req(1'b1, 10'h120, 4'd1, 64'h04);
        check(arm_evt == 3'b010, "R9 timer1 enable arms", 64'(arm_evt), 64'h2);
        do_req(1'b1, 10'h140, 4'd1, 64'h30);
        check(stop_evt == 3'b100 && arm_evt == 3'b000, "R9 timer2 disable stops",
              {58'd0, arm_evt, stop_evt}, 64'h4);

        finish_run();
    end

endmodule